// File: doc/BRIEF.md
# Scan Test Sequencer

This block runs a complete scan test against a small sequential circuit that sits inside it: an 8-bit state register whose flops each carry a scan mux in front of a fixed next-state function. A table of patterns holds pairs of words, each a stimulus state and the response the healthy circuit is expected to produce. Software fills the table through a simple write port. A `start` pulse then runs patterns 0 through `pat_last`. For each pattern, the sequencer loads the stimulus serially. It then drops scan-enable for a single functional clock so the flops capture the next-state output. It returns to shifting straight away.

The response of one pattern is unloaded on the same clocks that load the stimulus of the next. Each bit leaving the chain is compared with its expected value as it appears. After the final capture, a flush of eight shifts brings out the last response and fills the chain with zeros. On the first mismatch of a run, a sticky fail flag is set and the number of the failing pattern is kept. The flag stays set until the next run starts.

The control is a five-state machine:

| State | Function |
|---|---|
| IDLE | Waits after reset. |
| SHIFT | Runs eight clocks of load plus unload. |
| CAPTURE | Runs the one functional clock. |
| FLUSH | Runs eight clocks that unload the last response. |
| DONE | Holds the result. |

The transitions are:

- IDLE→SHIFT on `start`.
- SHIFT→CAPTURE after the eighth bit.
- CAPTURE→SHIFT when patterns remain.
- CAPTURE→FLUSH after the last pattern.
- FLUSH→DONE after the eighth bit.
- DONE→SHIFT on a new `start`.

Top module: `scan_test_seq`

## Requirements
- R1: After reset, `busy`, `done`, `fail` and `chain_q` are all 0 and `scan_en_o` is 1.
- R2: Stimulus bits enter the chain bit 0 first. Each shift moves the chain one place from bit 7 toward bit 0, and `chain_q` bit 0 is the scan-out. In the cycle where `scan_en_o` is 0, `chain_q` equals the stimulus word exactly.
- R3: `scan_en_o` is 0 for exactly one cycle per pattern. After that cycle, `chain_q` equals the next-state function of the stimulus: rotate left by one, then XOR with 8'h5B.
- R4: Unloading response p overlaps loading stimulus p+1. A run of patterns 0..P lasts 9·(P+1)+8 clocks from the clock that accepts `start` to the first cycle with `done` high.
- R5: Each unloaded bit is compared with the matching bit of the expected word. On the first mismatch of a run, `fail` goes high and `fail_pat` takes that pattern's index. Later mismatches change neither.
- R6: Only patterns 0 through `pat_last`, sampled at start, are run and compared. Mismatching entries above `pat_last` set no fail.
- R7: While `busy` is high, table writes and `start` pulses are ignored.
- R8: The final response is unloaded by an 8-clock flush that shifts in zeros, so a mismatch in the last pattern is still caught and `chain_q` is 0 in DONE. The chain holds its value whenever no test is running.
- R9: `busy` is high only in SHIFT, CAPTURE and FLUSH, and `done` is high only in DONE. A `start` in DONE begins a new run and clears `fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle or done |
| pat_last | input | 3 | Index of the final pattern to run |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 3 | Table entry to write |
| wr_stim | input | 8 | Stimulus word to store |
| wr_exp | input | 8 | Expected response word to store |
| busy | output | 1 | Test in progress |
| done | output | 1 | Run finished |
| fail | output | 1 | Sticky mismatch flag |
| fail_pat | output | 3 | Pattern index of the first mismatch |
| scan_en_o | output | 1 | Scan-enable seen by the chain flops |
| chain_q | output | 8 | Present contents of the scan chain |

## Verification
The key overlap is a single shift clock that both pushes a stimulus bit of pattern p into the chain and compares the outgoing response bit of pattern p-1. The bench provokes it by corrupting single bits of expected words, including bit 7, which leaves the chain on the last shift before capture. It also corrupts the final pattern, whose response only leaves during the flush. It then judges `fail_pat` against a first-mismatch model and checks that every captured state still matches the stimulus loaded alongside the unload. A second collision, a write and a start landing mid-run, is judged by an unchanged run length and an unchanged verdict.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_CAPTURE,
        ST_FLUSH,
        ST_DONE
    } seq_state_t;

endpackage

// File: rtl/scan_chain_dut.sv
module scan_chain_dut #(
    parameter int unsigned            CHAIN_LEN = 8,
    parameter logic [CHAIN_LEN-1:0]   NS_KEY    = 8'h5B
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ce,
    input  logic                 se,
    input  logic                 si,
    output logic                 so,
    output logic [CHAIN_LEN-1:0] q
);

    logic [CHAIN_LEN-1:0] func_d;

    // functional next-state logic: rotate left by one, then mix in a key
    always_comb begin
        func_d = {q[CHAIN_LEN-2:0], q[CHAIN_LEN-1]} ^ NS_KEY;
    end

    // one scan flop per bit; the flop nearest scan-in is the top bit
    for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_flop
        logic shift_src;
        if (i == CHAIN_LEN - 1) begin : g_head
            assign shift_src = si;
        end else begin : g_body
            assign shift_src = q[i+1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[i] <= 1'b0;
            end else if (ce) begin
                q[i] <= se ? shift_src : func_d[i];
            end
        end
    end

    assign so = q[0];

    AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && se) |=> (q[CHAIN_LEN-2:0] == $past(q[CHAIN_LEN-1:1]))); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(q)); // R8

endmodule

// File: rtl/scan_pattern_store.sv
module scan_pattern_store #(
    parameter int unsigned CHAIN_LEN = 8,
    parameter int unsigned NPAT      = 8,
    localparam int unsigned PIDX_W   = $clog2(NPAT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lock,
    input  logic                 wr_en,
    input  logic [PIDX_W-1:0]    wr_idx,
    input  logic [CHAIN_LEN-1:0] wr_stim,
    input  logic [CHAIN_LEN-1:0] wr_exp,
    input  logic [PIDX_W-1:0]    stim_idx,
    input  logic [PIDX_W-1:0]    exp_idx,
    output logic [CHAIN_LEN-1:0] stim_word,
    output logic [CHAIN_LEN-1:0] exp_word
);

    logic [NPAT-1:0][CHAIN_LEN-1:0] stim_mem;
    logic [NPAT-1:0][CHAIN_LEN-1:0] exp_mem;

    for (genvar e = 0; e < NPAT; e++) begin : g_entry
        logic hit;
        assign hit = wr_en && !lock && (wr_idx == PIDX_W'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stim_mem[e] <= '0;
                exp_mem[e]  <= '0;
            end else if (hit) begin
                stim_mem[e] <= wr_stim;
                exp_mem[e]  <= wr_exp;
            end
        end
    end

    // two independent read ports: one loads, one checks the previous pattern
    assign stim_word = stim_mem[stim_idx];
    assign exp_word  = exp_mem[exp_idx];

    AST_MEM_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> ($stable(stim_mem) && $stable(exp_mem))); // R7

endmodule

// File: rtl/scan_resp_check.sv
module scan_resp_check #(
    parameter int unsigned NPAT    = 8,
    localparam int unsigned PIDX_W = $clog2(NPAT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              valid,
    input  logic              obs_bit,
    input  logic              exp_bit,
    input  logic [PIDX_W-1:0] pat_idx,
    output logic              fail,
    output logic [PIDX_W-1:0] fail_idx
);

    logic miss;
    assign miss = valid && (obs_bit ^ exp_bit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail     <= 1'b0;
            fail_idx <= '0;
        end else if (clr) begin
            fail     <= 1'b0;
            fail_idx <= '0;
        end else if (miss && !fail) begin
            fail     <= 1'b1;
            fail_idx <= pat_idx;
        end
    end

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !clr) |=> fail); // R5

    AST_FAIL_IDX_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !clr) |=> $stable(fail_idx)); // R5

endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
    import scan_seq_pkg::*;
#(
    parameter int unsigned CHAIN_LEN = 8,
    parameter int unsigned NPAT      = 8,
    localparam int unsigned BIT_W    = $clog2(CHAIN_LEN),
    localparam int unsigned PIDX_W   = $clog2(NPAT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PIDX_W-1:0] pat_last,
    output logic              busy,
    output logic              done,
    output logic              se,
    output logic              ce,
    output logic              fill_zero,
    output logic              clr,
    output logic              cmp_valid,
    output logic [PIDX_W-1:0] cmp_idx,
    output logic [PIDX_W-1:0] load_idx,
    output logic [BIT_W-1:0]  bit_idx
);

    seq_state_t        state_q, state_d;
    logic [BIT_W-1:0]  bit_q;
    logic [PIDX_W-1:0] pat_q;
    logic [PIDX_W-1:0] last_q;
    logic              have_prev_q;
    logic              accept;
    logic              bit_end;

    assign accept  = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));
    assign bit_end = (bit_q == BIT_W'(CHAIN_LEN - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_SHIFT;
            ST_SHIFT:   if (bit_end) state_d = ST_CAPTURE;
            ST_CAPTURE: state_d = (pat_q == last_q) ? ST_FLUSH : ST_SHIFT;
            ST_FLUSH:   if (bit_end) state_d = ST_DONE;
            ST_DONE:    if (start) state_d = ST_SHIFT;
        endcase
    end

    // bit and pattern counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q       <= '0;
            pat_q       <= '0;
            last_q      <= '0;
            have_prev_q <= 1'b0;
        end else if (accept) begin
            bit_q       <= '0;
            pat_q       <= '0;
            last_q      <= pat_last;
            have_prev_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_SHIFT, ST_FLUSH: begin
                    bit_q <= bit_end ? '0 : bit_q + 1'b1;
                end
                ST_CAPTURE: begin
                    have_prev_q <= 1'b1;
                    if (pat_q != last_q) begin
                        pat_q <= pat_q + 1'b1;
                    end
                end
                ST_IDLE, ST_DONE: begin
                    bit_q <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = 1'b0;
        done      = 1'b0;
        se        = 1'b1;
        ce        = 1'b0;
        fill_zero = 1'b0;
        cmp_valid = 1'b0;
        cmp_idx   = pat_q;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_SHIFT: begin
                busy      = 1'b1;
                ce        = 1'b1;
                cmp_valid = have_prev_q;
                cmp_idx   = pat_q - 1'b1;
            end
            ST_CAPTURE: begin
                busy = 1'b1;
                ce   = 1'b1;
                se   = 1'b0;
            end
            ST_FLUSH: begin
                busy      = 1'b1;
                ce        = 1'b1;
                fill_zero = 1'b1;
                cmp_valid = 1'b1;
            end
            ST_DONE: begin
                done = 1'b1;
            end
        endcase
    end

    assign clr      = accept;
    assign load_idx = pat_q;
    assign bit_idx  = bit_q;

    AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !se |=> se); // R3

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R9

    AST_CMP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |-> (cmp_idx <= last_q)); // R6

endmodule

// File: rtl/scan_test_seq.sv
module scan_test_seq #(
    parameter int unsigned CHAIN_LEN = 8,
    parameter int unsigned NPAT      = 8,
    parameter logic [CHAIN_LEN-1:0] NS_KEY = 8'h5B,
    localparam int unsigned BIT_W    = $clog2(CHAIN_LEN),
    localparam int unsigned PIDX_W   = $clog2(NPAT)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [PIDX_W-1:0]    pat_last,
    input  logic                 wr_en,
    input  logic [PIDX_W-1:0]    wr_idx,
    input  logic [CHAIN_LEN-1:0] wr_stim,
    input  logic [CHAIN_LEN-1:0] wr_exp,
    output logic                 busy,
    output logic                 done,
    output logic                 fail,
    output logic [PIDX_W-1:0]    fail_pat,
    output logic                 scan_en_o,
    output logic [CHAIN_LEN-1:0] chain_q
);

    logic                 se, ce, fill_zero, clr, cmp_valid;
    logic [PIDX_W-1:0]    cmp_idx, load_idx;
    logic [BIT_W-1:0]     bit_idx;
    logic [CHAIN_LEN-1:0] stim_word, exp_word;
    logic                 scan_in, scan_out;

    scan_seq_ctrl #(.CHAIN_LEN(CHAIN_LEN), .NPAT(NPAT)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .pat_last  (pat_last),
        .busy      (busy),
        .done      (done),
        .se        (se),
        .ce        (ce),
        .fill_zero (fill_zero),
        .clr       (clr),
        .cmp_valid (cmp_valid),
        .cmp_idx   (cmp_idx),
        .load_idx  (load_idx),
        .bit_idx   (bit_idx)
    );

    scan_pattern_store #(.CHAIN_LEN(CHAIN_LEN), .NPAT(NPAT)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock      (busy),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_stim   (wr_stim),
        .wr_exp    (wr_exp),
        .stim_idx  (load_idx),
        .exp_idx   (cmp_idx),
        .stim_word (stim_word),
        .exp_word  (exp_word)
    );

    assign scan_in = fill_zero ? 1'b0 : stim_word[bit_idx];

    scan_chain_dut #(.CHAIN_LEN(CHAIN_LEN), .NS_KEY(NS_KEY)) u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (ce),
        .se    (se),
        .si    (scan_in),
        .so    (scan_out),
        .q     (chain_q)
    );

    scan_resp_check #(.NPAT(NPAT)) u_check (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .valid    (cmp_valid),
        .obs_bit  (scan_out),
        .exp_bit  (exp_word[bit_idx]),
        .pat_idx  (cmp_idx),
        .fail     (fail),
        .fail_idx (fail_pat)
    );

    assign scan_en_o = se;

endmodule

// File: tb/scan_test_seq_test.sv
module scan_test_seq_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] pat_last = '0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_idx = '0;
    logic [7:0] wr_stim = '0;
    logic [7:0] wr_exp = '0;
    logic       busy, done, fail, scan_en_o;
    logic [2:0] fail_pat;
    logic [7:0] chain_q;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    logic [7:0] tb_stim [8];
    logic [7:0] tb_exp  [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    scan_test_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .pat_last(pat_last),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_stim(wr_stim), .wr_exp(wr_exp),
        .busy(busy), .done(done), .fail(fail), .fail_pat(fail_pat),
        .scan_en_o(scan_en_o), .chain_q(chain_q)
    );

    function automatic logic [7:0] nf(input logic [7:0] s);
        return {s[6:0], s[7]} ^ 8'h5B;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    task automatic load_table();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_idx = 3'(i); wr_stim = tb_stim[i]; wr_exp = tb_exp[i];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic fill_good();
        for (int i = 0; i < 8; i++) begin
            tb_stim[i] = 8'($urandom);
            tb_exp[i]  = nf(tb_stim[i]);
        end
    endtask

    task automatic run(input int pl, input bit inject, input string tag);
        int n = 0;
        int cap = 0;
        bit prev_cap = 1'b0;
        int exp_fail = -1;
        for (int p = 0; p <= pl; p++)
            if (exp_fail < 0 && tb_exp[p] != nf(tb_stim[p])) exp_fail = p;
        @(negedge clk);
        start = 1'b1; pat_last = 3'(pl);
        @(negedge clk);
        start = 1'b0;
        while (!done && n < 1000) begin
            if (!scan_en_o) begin
                check(chain_q == tb_stim[cap], {"R2 load ", tag}, chain_q, tb_stim[cap]);
                prev_cap = 1'b1;
            end else if (prev_cap) begin
                check(chain_q == nf(tb_stim[cap]), {"R3 capture ", tag}, chain_q, nf(tb_stim[cap]));
                cap++;
                prev_cap = 1'b0;
            end
            if (inject && n == 3) begin
                wr_en = 1'b1; wr_idx = 3'(pl);
                wr_stim = ~tb_stim[pl]; wr_exp = ~tb_exp[pl]; start = 1'b1;
            end else begin
                wr_en = 1'b0; start = 1'b0;
            end
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        wr_en = 1'b0; start = 1'b0;
        check(n == 9*(pl+1)+8, {"R4 run length ", tag}, n, 9*(pl+1)+8);
        check(cap == pl+1, {"R3 capture count ", tag}, cap, pl+1);
        check(fail == (exp_fail >= 0), {"R5 fail flag ", tag}, fail, exp_fail >= 0);
        if (exp_fail >= 0)
            check(fail_pat == 3'(exp_fail), {"R5 fail index ", tag}, fail_pat, exp_fail);
        check(chain_q == 8'h00, {"R8 flushed chain ", tag}, chain_q, 0);
        check(done && !busy, {"R9 done state ", tag}, {done, busy}, 2);
        if (inject) begin
            check(n == 9*(pl+1)+8, {"R7 start ignored ", tag}, n, 9*(pl+1)+8);
            check(fail == (exp_fail >= 0), {"R7 write ignored ", tag}, fail, exp_fail >= 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5CA17E57));
        repeat (3) @(negedge clk);
        check(!busy && !done && !fail, "R1 reset flags", {busy, done, fail}, 0);
        check(chain_q == 8'h00, "R1 reset chain", chain_q, 0);
        check(scan_en_o == 1'b1, "R1 reset scan_en", scan_en_o, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(chain_q == 8'h00 && !busy, "R8 hold while idle", chain_q, 0);

        // directed: all good, corner words
        fill_good();
        tb_stim[0] = 8'h00; tb_exp[0] = nf(8'h00);
        tb_stim[1] = 8'hFF; tb_exp[1] = nf(8'hFF);
        tb_stim[2] = 8'h80; tb_exp[2] = nf(8'h80);
        load_table();
        run(7, 1'b0, "all good");

        // R5: bit 7 mismatch in pattern 2 and another in 5 -> first is 2
        tb_exp[2] = tb_exp[2] ^ 8'h80;
        tb_exp[5] = tb_exp[5] ^ 8'h01;
        load_table();
        run(7, 1'b0, "first of two misses");

        // R8: mismatch only in the final pattern, seen during flush
        fill_good();
        tb_exp[7] = tb_exp[7] ^ 8'h10;
        load_table();
        run(7, 1'b0, "last pattern miss");

        // R9: restart from DONE clears fail
        tb_exp[7] = nf(tb_stim[7]);
        load_table();
        run(7, 1'b0, "restart clears");

        // R6: single pattern, and miss beyond pat_last ignored
        run(0, 1'b0, "single pattern");
        tb_exp[5] = tb_exp[5] ^ 8'h04;
        load_table();
        run(3, 1'b0, "miss beyond last");

        // R7: write and start during a run have no effect
        fill_good();
        load_table();
        run(4, 1'b1, "inject mid-run");

        // random runs
        for (int r = 0; r < 8; r++) begin
            fill_good();
            for (int i = 0; i < 8; i++)
                if (($urandom % 4) == 0) tb_exp[i] = tb_exp[i] ^ (8'h01 << ($urandom % 8));
            load_table();
            run(int'($urandom % 8), 1'b0, "random");
        end

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule